// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is one direction of a bidirectional buffer. It holds 18-bit words in a memory of 256 entries by default, and the depth can be set to 512. The write side and the read side run on unrelated clocks. A producer pushes words on the write clock. A consumer pops them on the read clock in the same order.

Four status flags describe the occupancy. Full and almost-full are produced in the write-clock domain. Empty and almost-empty are produced in the read-clock domain. Each side sees the other side's pointer through a gray-coded, two-flop synchronizer.

The two almost-flag thresholds live in registers. A small select/address/data interface loads them on the write clock, at run time. A threshold can take any value from zero up to the full depth.

Top module: `xdom_fifo`

## Requirements
- R1: While `rstN` is low, and after it is released, the FIFO holds no words. Empty and almost-empty read 1, full and almost-full read 0, and both thresholds return to 8.
- R2: Words come out in the order they were written. A read accepted at a rising `rdClk` edge places its word on `rdData` right after that same edge. The word stays there until the next accepted read.
- R3: A write is accepted at a rising `wrClk` edge when `wrEn` is 1 and `full` is 0. `full` reads 1 exactly when DEPTH words are stored, and it clears once words have been read and the read pointer has crossed to the write side.
- R4: A write attempted while `full` is 1 is dropped. The stored contents and the write pointer stay unchanged, and `full` stays 1.
- R5: A read attempted while `empty` is 1 is dropped. `rdData` and the read pointer stay unchanged.
- R6: `almostEmpty` is 1 when the word count seen by the read side is at or below the empty threshold.
- R7: `almostFull` is 1 when the free space seen by the write side is at or below the full threshold.
- R8: When `cfgSel` is 1 at a rising `wrClk` edge, `cfgData` is loaded into one threshold chosen by `cfgAddr`. Address 0 selects the empty threshold and address 1 selects the full threshold. Every other address has no effect.
- R9: The pointers cross domains as gray code through two flops. A word written into an empty FIFO is not yet visible as non-empty at the first read-clock falling edge after the write. It is visible within four read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write request |
| wrData | input | 18 | Word to store |
| full | output | 1 | No free entry (write domain) |
| almostFull | output | 1 | Free space at or below the full threshold |
| cfgSel | input | 1 | Threshold register write select (write clock) |
| cfgAddr | input | 3 | Threshold register address |
| cfgData | input | log2(DEPTH)+1 | Threshold value |
| rdEn | input | 1 | Read request |
| rdData | output | 18 | Registered output word |
| empty | output | 1 | No stored word (read domain) |
| almostEmpty | output | 1 | Word count at or below the empty threshold |

## Verification
The scoreboard is exercised in three ways:
- Burst fills and drains with only one side active separate the flag arithmetic from the crossing.
- A fill up to the exact depth, followed by an extra write, shows whether a dropped write ever reaches storage.
- A long concurrent stream with a throttled reader and an occasionally idle writer exercises ordering while both pointers move and cross at the same time.

Threshold tests load values that differ from the defaults and write to an unused address. This separates correct address decoding from stale defaults. A mid-stream reset shows whether the thresholds and flags are restored rather than retained.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
  } xdomStrobe_t;

  localparam int CFG_SEL_EMPTY_OFS = 0;
  localparam int CFG_SEL_FULL_OFS  = 1;

endpackage

// File: rtl/xdom_fifo_store.sv
module xdom_fifo_store #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                       wrClk,
  input  logic                       rdClk,
  input  logic                       rstN,
  input  xdom_fifo_pkg::xdomStrobe_t strobe,
  input  logic [AW-1:0]              wrAddr,
  input  logic [AW-1:0]              rdAddr,
  input  logic [WIDTH-1:0]           wrData,
  output logic [WIDTH-1:0]           rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdStrobe) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/xdom_fifo_ctrl.sv
module xdom_fifo_ctrl #(
  parameter int DEPTH   = 256,
  parameter int CFG_AW  = 3,
  parameter int DEF_OFS = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                        wrClk,
  input  logic                        rdClk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic                        cfgSel,
  input  logic [CFG_AW-1:0]           cfgAddr,
  input  logic [PW-1:0]               cfgData,
  output xdom_fifo_pkg::xdomStrobe_t  strobe,
  output logic [AW-1:0]               wrAddr,
  output logic [AW-1:0]               rdAddr,
  output logic [PW-1:0]               wrGray,
  output logic [PW-1:0]               rdGray,
  output logic                        full,
  output logic                        almostFull,
  output logic                        empty,
  output logic                        almostEmpty
);
  import xdom_fifo_pkg::*;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [PW-1:0] wrBin, wrBinNext, rdSyncA, rdSyncB, wrUsed, wrFree;
  logic [PW-1:0] fullOfs, emptyOfsWr;

  assign strobe.wrStrobe = wrEn & ~full;
  assign wrBinNext       = wrBin + PW'(1);
  assign full            = (wrGray == {~rdSyncB[PW-1:PW-2], rdSyncB[PW-3:0]});
  assign wrUsed          = wrBin - grayToBin(rdSyncB);
  assign wrFree          = PW'(DEPTH) - wrUsed;
  assign almostFull      = (wrFree <= fullOfs);
  assign wrAddr          = wrBin[AW-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin      <= '0;
      wrGray     <= '0;
      rdSyncA    <= '0;
      rdSyncB    <= '0;
      fullOfs    <= PW'(DEF_OFS);
      emptyOfsWr <= PW'(DEF_OFS);
    end else begin
      rdSyncA <= rdGray;
      rdSyncB <= rdSyncA;
      if (strobe.wrStrobe) begin
        wrBin  <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
      if (cfgSel && cfgAddr == CFG_AW'(CFG_SEL_EMPTY_OFS)) emptyOfsWr <= cfgData;
      if (cfgSel && cfgAddr == CFG_AW'(CFG_SEL_FULL_OFS))  fullOfs    <= cfgData;
    end
  end

  // read domain
  logic [PW-1:0] rdBin, rdBinNext, wrSyncA, wrSyncB, rdCount;
  logic [PW-1:0] emptyOfsA, emptyOfsB;

  assign strobe.rdStrobe = rdEn & ~empty;
  assign rdBinNext       = rdBin + PW'(1);
  assign empty           = (rdGray == wrSyncB);
  assign rdCount         = grayToBin(wrSyncB) - rdBin;
  assign almostEmpty     = (rdCount <= emptyOfsB);
  assign rdAddr          = rdBin[AW-1:0];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin     <= '0;
      rdGray    <= '0;
      wrSyncA   <= '0;
      wrSyncB   <= '0;
      emptyOfsA <= PW'(DEF_OFS);
      emptyOfsB <= PW'(DEF_OFS);
    end else begin
      wrSyncA   <= wrGray;
      wrSyncB   <= wrSyncA;
      emptyOfsA <= emptyOfsWr;   // quasi-static threshold copy
      emptyOfsB <= emptyOfsA;
      if (strobe.rdStrobe) begin
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
    end
  end

endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 256,
  parameter int CFG_AW  = 3,
  parameter int DEF_OFS = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PTR_W = AW + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  wrData,
  output logic              full,
  output logic              almostFull,
  input  logic              cfgSel,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [PTR_W-1:0]  cfgData,
  input  logic              rdEn,
  output logic [WIDTH-1:0]  rdData,
  output logic              empty,
  output logic              almostEmpty
);

  xdom_fifo_pkg::xdomStrobe_t strobe;
  logic [AW-1:0]    wrAddr, rdAddr;
  logic [PTR_W-1:0] wrPtrGray, rdPtrGray;

  xdom_fifo_ctrl #(.DEPTH(DEPTH), .CFG_AW(CFG_AW), .DEF_OFS(DEF_OFS)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn),
    .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrGray(wrPtrGray), .rdGray(rdPtrGray),
    .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  xdom_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
  parameter int WIDTH = 18,
  parameter int PW    = 9
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic             full,
  input logic             almostFull,
  input logic             empty,
  input logic             almostEmpty,
  input logic [WIDTH-1:0] rdData,
  input logic [PW-1:0]    wrGray,
  input logic [PW-1:0]    rdGray
);

  a_r4_full_write_dropped: assert property (@(posedge wrClk) disable iff (!rstN)
    (full && wrEn) |=> $stable(wrGray));

  a_r5_empty_read_dropped: assert property (@(posedge rdClk) disable iff (!rstN)
    (empty && rdEn) |=> ($stable(rdData) && $stable(rdGray)));

  a_r6_empty_implies_almost: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty);

  a_r7_full_implies_almost: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull);

  a_r9_wr_gray_one_bit: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  a_r9_rd_gray_one_bit: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);

endmodule

bind xdom_fifo xdom_fifo_chk #(.WIDTH(WIDTH), .PW(PTR_W)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEn(wrEn), .rdEn(rdEn),
  .full(full), .almostFull(almostFull),
  .empty(empty), .almostEmpty(almostEmpty),
  .rdData(rdData), .wrGray(wrPtrGray), .rdGray(rdPtrGray)
);

// File: tb/xdom_fifo_tb_top.sv
`timescale 1ns/1ps
module xdom_fifo_tb_top;
  localparam int WIDTH = 18;
  localparam int DEPTH = 256;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrEn = 0, rdEn = 0, cfgSel = 0;
  logic [WIDTH-1:0] wrData = '0;
  logic [2:0] cfgAddr = '0;
  logic [PW-1:0] cfgData = '0;
  logic full, almostFull, empty, almostEmpty;
  logic [WIDTH-1:0] rdData;

  always #10 wrClk = ~wrClk;   // 50 MHz
  always #17 rdClk = ~rdClk;

  xdom_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .full(full), .almostFull(almostFull),
    .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .rdEn(rdEn), .rdData(rdData), .empty(empty), .almostEmpty(almostEmpty)
  );

  int checks = 0, errs = 0;
  bit done = 0, readGo = 0, forceRd = 0, rdPend = 0;
  logic [WIDTH-1:0] sb[$];
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare each accepted read against the scoreboard (R2)
  initial forever begin
    @(negedge rdClk);
    if (rdPend) begin
      if (sb.size() == 0) chk(0, "R2 unexpected read word", int'(rdData), -1);
      else begin
        logic [WIDTH-1:0] exp;
        exp = sb.pop_front();
        chk(rdData == exp, "R2 read order/latency", int'(rdData), int'(exp));
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdEn   = forceRd | (readGo & (lfsr[0] | lfsr[1]));
    rdPend = rstN && rdEn && !empty;
  end

  task automatic wrWord(input logic [WIDTH-1:0] d, output bit took);
    @(negedge wrClk);
    took = !full;
    wrEn = 1; wrData = d;
    if (took) sb.push_back(d);
  endtask

  task automatic wrIdle();
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic wrMany(input int n, input logic [WIDTH-1:0] base);
    bit took;
    for (int i = 0; i < n; i++) wrWord(base + WIDTH'(i), took);
    wrIdle();
  endtask

  task automatic rdWait(input int n); repeat (n) @(negedge rdClk); endtask
  task automatic wrWait(input int n); repeat (n) @(negedge wrClk); endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [PW-1:0] v);
    @(negedge wrClk); cfgSel = 1; cfgAddr = a; cfgData = v;
    @(negedge wrClk); cfgSel = 0;
    rdWait(4);
  endtask

  task automatic drain();
    int t = 0;
    readGo = 1;
    while (sb.size() != 0 && t < 5000) begin @(negedge rdClk); t++; end
    readGo = 0;
    rdWait(3);
    chk(sb.size() == 0, "R2 drain complete", sb.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    bit took;
    logic [WIDTH-1:0] held;
    wrWait(3);
    chk(empty == 1 && almostEmpty == 1, "R1 empty flags in reset", {empty, almostEmpty}, 3);
    rstN = 1;
    rdWait(3);
    chk(empty == 1, "R1 empty after reset", empty, 1);
    chk(almostEmpty == 1, "R1 almostEmpty after reset", almostEmpty, 1);
    chk(full == 0 && almostFull == 0, "R1 full flags after reset", {full, almostFull}, 0);

    // R9 crossing latency of a single write
    @(negedge wrClk); wrEn = 1; wrData = 18'h00100; sb.push_back(wrData);
    @(posedge wrClk); #1 wrEn = 0;
    @(negedge rdClk);
    chk(empty == 1, "R9 empty still set right after write", empty, 1);
    rdWait(4);
    chk(empty == 0, "R9 word visible within four read cycles", empty, 0);

    // R6 with default threshold 8
    wrMany(7, 18'h00101);
    rdWait(5);
    chk(almostEmpty == 1, "R6 count 8 at default threshold", almostEmpty, 1);
    wrMany(1, 18'h00200);
    rdWait(5);
    chk(almostEmpty == 0, "R6 count 9 above default threshold", almostEmpty, 0);
    drain();
    chk(empty == 1, "R2 empty after drain", empty, 1);

    // R8 thresholds and unused address
    cfgWrite(3'd0, PW'(3));
    cfgWrite(3'd1, PW'(20));
    cfgWrite(3'd2, PW'(100));
    wrMany(3, 18'h01000);
    rdWait(5);
    chk(almostEmpty == 1, "R8 empty threshold 3 at count 3", almostEmpty, 1);
    wrMany(1, 18'h01003);
    rdWait(5);
    chk(almostEmpty == 0, "R8 empty threshold 3 at count 4", almostEmpty, 0);
    drain();

    // R7 / R3 / R4 fill to depth
    wrMany(235, 18'h02000);
    chk(almostFull == 0, "R7 free 21 above threshold 20", almostFull, 0);
    wrMany(1, 18'h03000);
    chk(almostFull == 1, "R7 free 20 at threshold", almostFull, 1);
    chk(full == 0, "R3 not full below depth", full, 0);
    wrMany(20, 18'h03100);
    chk(full == 1, "R3 full at depth", full, 1);
    wrWord(18'h3FFFF, took);
    wrIdle();
    chk(full == 1, "R4 full held after dropped write", full, 1);
    drain();
    wrWait(4);
    chk(full == 0, "R3 full clears after reads cross", full, 0);
    chk(empty == 1, "R4 no extra word stored", empty, 1);

    // R5 read while empty
    held = rdData;
    forceRd = 1;
    rdWait(5);
    forceRd = 0;
    rdWait(1);
    chk(rdData == held, "R5 rdData held on empty read", int'(rdData), int'(held));
    wrMany(1, 18'h2A5A5);
    rdWait(5);
    drain();

    // R2 concurrent stream
    readGo = 1;
    for (int i = 0; i < 600; i++) begin
      do wrWord(18'h10000 + WIDTH'(i), took); while (!took);
      if (i % 7 == 6) wrIdle();
    end
    wrIdle();
    drain();

    // R1 reset mid-stream restores thresholds
    wrMany(10, 18'h04000);
    @(negedge wrClk); rstN = 0;
    sb.delete();
    wrWait(3);
    rstN = 1;
    rdWait(3);
    chk(empty == 1 && almostEmpty == 1, "R1 empty flags after mid reset", {empty, almostEmpty}, 3);
    chk(full == 0 && almostFull == 0, "R1 full flags after mid reset", {full, almostFull}, 0);
    wrMany(8, 18'h05000);
    rdWait(5);
    chk(almostEmpty == 1, "R1 threshold back to 8 at count 8", almostEmpty, 1);
    wrMany(1, 18'h05008);
    rdWait(5);
    chk(almostEmpty == 0, "R1 threshold back to 8 at count 9", almostEmpty, 0);
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule